// File: doc/BRIEF.md
# Nibble-Split Serial Display Transmitter

This block moves command and pixel-data bytes from a host into a graphic display controller over a three-wire synchronous link. The link has a serial clock, a serial data line and a chip select that is active high. The host hands over one payload byte at a time through a valid/ready handshake.

The block sends each payload byte as up to three serial bytes, most significant bit first. The first is an optional type byte that marks command or data. The second carries the upper nibble of the payload. The third carries the lower nibble. After the last bit the block holds off the host for a fixed settle time, so the controller can finish processing the byte.

The block keeps a register-select state with three values: command, data and continue. Any accepted byte moves the state to continue. In that state the type byte is left out, which makes a run of data bytes cheaper to send. The host returns the state to command or data with a separate mode-set input. The display reset line and the chip select follow host-supplied levels.

Top module: `nibser_tx`

## Requirements
- R1: After reset, `ser_clk`, `ser_dat` and `ser_cs` are low, `req_ready` is high, and the register-select state is command.
- R2: `disp_rst` equals `rst_level` in the same cycle, with no register between them.
- R3: `ser_cs` is active high and equals the value `cs_en` had in the previous clock cycle.
- R4: A byte accepted in command state is preceded on the link by the type byte 0xF8.
- R5: A mode-set with `mode_set_data`=1 selects data state, and a byte sent in data state is preceded by 0xFA. A mode-set with `mode_set_data`=0 selects command state.
- R6: After the optional type byte, the block sends {payload[7:4], 4'b0000} and then {payload[3:0], 4'b0000}.
- R7: Every accepted byte moves the state to continue. A byte accepted in continue state is sent as its two nibble bytes only, with no type byte.
- R8: Each bit is sent in two parts. First `ser_dat` is set while `ser_clk` is low for HALF_CYC cycles. Then `ser_clk` is high for HALF_CYC cycles. `ser_dat` does not change while `ser_clk` is high, and bits go out most significant bit first.
- R9: From the acceptance edge, `req_ready` stays low for n*(16*HALF_CYC+1)+SETTLE_CYC cycles, where n is the number of serial bytes in the frame (2 or 3).
- R10: A mode-set in the same cycle as a byte acceptance applies to that byte.
- R11: A mode-set while a frame is in flight does not change that frame. It applies to the next accepted byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host offers a payload byte |
| req_byte | input | 8 | Payload byte |
| req_ready | output | 1 | Block can accept a byte |
| mode_set_valid | input | 1 | Set the register-select state |
| mode_set_data | input | 1 | 1 = data state, 0 = command state |
| cs_en | input | 1 | Host chip-select level |
| rst_level | input | 1 | Host display-reset level |
| ser_clk | output | 1 | Serial clock |
| ser_dat | output | 1 | Serial data, MSB first |
| ser_cs | output | 1 | Chip select, active high |
| disp_rst | output | 1 | Display reset line |

## Verification
Two things can happen in the same cycle: a mode-set and the acceptance of a byte. The bench drives both together and expects the new mode to decide that byte's type byte. The register-select state must still end in continue afterwards. The bench also issues a mode-set while a frame is being shifted out. The frame in flight must keep its two-byte form, and the next byte must carry the newly selected type byte. A scoreboard decodes the serial stream, and a count of how long `req_ready` stays low checks the frame length against the settle time.

// File: rtl/nibser_pkg.sv
package nibser_pkg;

    localparam int BYTE_W = 8;
    localparam int NIB_W  = 4;

    typedef enum logic [1:0] {
        RS_CMD  = 2'd0,
        RS_DATA = 2'd1,
        RS_CONT = 2'd2
    } rs_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREFIX,
        ST_HI,
        ST_LO,
        ST_SETTLE
    } seq_state_e;

    localparam logic [BYTE_W-1:0] TYPE_CMD  = 8'hF8;
    localparam logic [BYTE_W-1:0] TYPE_DATA = 8'hFA;

    function automatic logic [BYTE_W-1:0] type_byte(rs_mode_e m);
        return (m == RS_DATA) ? TYPE_DATA : TYPE_CMD;
    endfunction

    function automatic logic [BYTE_W-1:0] upper_frame(logic [BYTE_W-1:0] b);
        return {b[BYTE_W-1:NIB_W], {NIB_W{1'b0}}};
    endfunction

    function automatic logic [BYTE_W-1:0] lower_frame(logic [BYTE_W-1:0] b);
        return {b[NIB_W-1:0], {NIB_W{1'b0}}};
    endfunction

endpackage

// File: rtl/nibser_shift.sv
module nibser_shift
    import nibser_pkg::*;
#(
    parameter int HALF_CYC = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [BYTE_W-1:0] din,
    output logic              busy,
    output logic              done,
    output logic              sclk,
    output logic              sdat
);
    localparam int TW = $clog2(HALF_CYC + 1);
    localparam int BW = $clog2(BYTE_W);
    localparam logic [TW-1:0] T_LAST = TW'(HALF_CYC - 1);
    localparam logic [BW-1:0] B_LAST = BW'(BYTE_W - 1);

    logic [BYTE_W-1:0] sh;
    logic [TW-1:0]     tcnt;
    logic [BW-1:0]     bitc;
    logic              phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            sh    <= '0;
            tcnt  <= '0;
            bitc  <= '0;
            phase <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy  <= 1'b1;
                sh    <= din;
                tcnt  <= '0;
                bitc  <= '0;
                phase <= 1'b0;
            end else if (busy) begin
                if (tcnt == T_LAST) begin
                    tcnt  <= '0;
                    phase <= ~phase;
                    if (phase) begin
                        sh   <= {sh[BYTE_W-2:0], 1'b0};
                        bitc <= bitc + 1'b1;
                        if (bitc == B_LAST) begin
                            busy <= 1'b0;
                            done <= 1'b1;
                        end
                    end
                end else begin
                    tcnt <= tcnt + 1'b1;
                end
            end
        end
    end

    assign sclk = phase;
    assign sdat = sh[BYTE_W-1];

    // R8: data held steady across the high half of each bit
    p_dat_stable_r8: assert property (@(posedge clk) disable iff (rst)
        (phase && $past(phase)) |-> $stable(sh[BYTE_W-1]));

    // R8: completion is a single-cycle pulse
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/nibser_mode.sv
module nibser_mode
    import nibser_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     set_valid,
    input  logic     set_data,
    input  logic     fire,
    output rs_mode_e eff_mode
);
    rs_mode_e mode_q;

    always_comb begin
        if (set_valid) eff_mode = set_data ? RS_DATA : RS_CMD;
        else           eff_mode = mode_q;
    end

    always_ff @(posedge clk) begin
        if (rst)            mode_q <= RS_CMD;
        else if (fire)      mode_q <= RS_CONT;
        else if (set_valid) mode_q <= set_data ? RS_DATA : RS_CMD;
    end

    // R7: accepted byte leaves the state in continue
    p_cont_after_fire_r7: assert property (@(posedge clk) disable iff (rst)
        fire |=> (mode_q == RS_CONT));

endmodule

// File: rtl/nibser_seq.sv
module nibser_seq
    import nibser_pkg::*;
#(
    parameter int SETTLE_CYC = 8000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [BYTE_W-1:0] req_byte,
    input  rs_mode_e          eff_mode,
    input  logic              sh_busy,
    input  logic              sh_done,
    output logic              req_ready,
    output logic              fire,
    output logic              sh_start,
    output logic [BYTE_W-1:0] sh_din
);
    localparam int CW = $clog2(SETTLE_CYC + 1);
    localparam logic [CW-1:0] C_LOAD = CW'(SETTLE_CYC - 1);

    seq_state_e        state;
    logic [BYTE_W-1:0] held;
    logic [CW-1:0]     scnt;

    assign req_ready = (state == ST_IDLE);
    assign fire      = req_valid && req_ready;

    always_comb begin
        sh_start = 1'b0;
        sh_din   = '0;
        case (state)
            ST_IDLE: begin
                sh_start = fire;
                sh_din   = (eff_mode == RS_CONT) ? upper_frame(req_byte)
                                                 : type_byte(eff_mode);
            end
            ST_PREFIX: begin
                sh_start = sh_done;
                sh_din   = upper_frame(held);
            end
            ST_HI: begin
                sh_start = sh_done;
                sh_din   = lower_frame(held);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            held  <= '0;
            scnt  <= '0;
        end else begin
            case (state)
                ST_IDLE: if (fire) begin
                    held  <= req_byte;
                    state <= (eff_mode == RS_CONT) ? ST_HI : ST_PREFIX;
                end
                ST_PREFIX: if (sh_done) state <= ST_HI;
                ST_HI:     if (sh_done) state <= ST_LO;
                ST_LO: if (sh_done) begin
                    state <= ST_SETTLE;
                    scnt  <= C_LOAD;
                end
                ST_SETTLE: begin
                    if (scnt == '0) state <= ST_IDLE;
                    else            scnt  <= scnt - 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R9: a new serial byte is only launched into an idle shifter
    p_start_idle_r9: assert property (@(posedge clk) disable iff (rst)
        sh_start |-> !sh_busy);

    // R9: the host is held off while the shifter works
    p_ready_low_busy_r9: assert property (@(posedge clk) disable iff (rst)
        sh_busy |-> !req_ready);

endmodule

// File: rtl/nibser_tx.sv
module nibser_tx
    import nibser_pkg::*;
#(
    parameter int HALF_CYC   = 20,
    parameter int SETTLE_CYC = 8000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic [7:0] req_byte,
    output logic       req_ready,
    input  logic       mode_set_valid,
    input  logic       mode_set_data,
    input  logic       cs_en,
    input  logic       rst_level,
    output logic       ser_clk,
    output logic       ser_dat,
    output logic       ser_cs,
    output logic       disp_rst
);
    rs_mode_e          eff_mode;
    logic              fire;
    logic              sh_start;
    logic              sh_busy;
    logic              sh_done;
    logic [BYTE_W-1:0] sh_din;

    nibser_mode u_mode (
        .clk       (clk),
        .rst       (rst),
        .set_valid (mode_set_valid),
        .set_data  (mode_set_data),
        .fire      (fire),
        .eff_mode  (eff_mode)
    );

    nibser_seq #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_byte  (req_byte),
        .eff_mode  (eff_mode),
        .sh_busy   (sh_busy),
        .sh_done   (sh_done),
        .req_ready (req_ready),
        .fire      (fire),
        .sh_start  (sh_start),
        .sh_din    (sh_din)
    );

    nibser_shift #(.HALF_CYC(HALF_CYC)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .start (sh_start),
        .din   (sh_din),
        .busy  (sh_busy),
        .done  (sh_done),
        .sclk  (ser_clk),
        .sdat  (ser_dat)
    );

    always_ff @(posedge clk) begin
        if (rst) ser_cs <= 1'b0;
        else     ser_cs <= cs_en;
    end

    assign disp_rst = rst_level;

    // R1: link quiet whenever the host may present a byte
    p_quiet_ready_r1: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!ser_clk && !ser_dat));

endmodule

// File: tb/nibser_tx_tb.sv
module nibser_tx_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int H = 2;
    localparam int S = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [7:0] req_byte = '0;
    logic req_ready;
    logic mode_set_valid = 1'b0;
    logic mode_set_data = 1'b0;
    logic cs_en = 1'b0;
    logic rst_level = 1'b0;
    logic ser_clk, ser_dat, ser_cs, disp_rst;

    always #2.5 clk = ~clk;

    nibser_tx #(.HALF_CYC(H), .SETTLE_CYC(S)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_byte(req_byte),
        .req_ready(req_ready), .mode_set_valid(mode_set_valid),
        .mode_set_data(mode_set_data), .cs_en(cs_en), .rst_level(rst_level),
        .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_cs(ser_cs), .disp_rst(disp_rst)
    );

    int n_total = 0;
    int n_fail  = 0;
    bit finished = 1'b0;
    int bmode = 0;   // 0 command, 1 data, 2 continue

    logic [7:0] exp_q[$];
    string      tag_q[$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: decode serial stream and compare against scoreboard queue
    logic prev_clk = 1'b0;
    logic prev_dat = 1'b0;
    logic [7:0] acc = '0;
    int nb = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (ser_clk && prev_clk && (ser_dat != prev_dat))
                chk(1'b0, "R8 data moved while clock high", ser_dat, prev_dat);
            if (ser_clk && !prev_clk) begin
                acc = {acc[6:0], ser_dat};
                nb++;
                if (nb == 8) begin
                    nb = 0;
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R7 unexpected serial byte", acc, 0);
                    end else begin
                        logic [7:0] e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        chk(acc == e, {t, " R8 serial byte"}, acc, e);
                    end
                end
            end
        end
        prev_clk = ser_clk;
        prev_dat = ser_dat;
    end

    task automatic set_mode(input bit data);
        @(negedge clk);
        mode_set_valid = 1'b1;
        mode_set_data  = data;
        @(negedge clk);
        mode_set_valid = 1'b0;
        bmode = data ? 1 : 0;
    endtask

    task automatic send(input logic [7:0] b, input bit do_set, input bit set_data,
                        input bit mid_set, input bit mid_data, input string tag);
        int m;
        int n;
        int n_exp;
        m = do_set ? (set_data ? 1 : 0) : bmode;
        if (m == 0) begin exp_q.push_back(8'hF8); tag_q.push_back(tag); end
        if (m == 1) begin exp_q.push_back(8'hFA); tag_q.push_back(tag); end
        exp_q.push_back({b[7:4], 4'h0}); tag_q.push_back("R6 upper");
        exp_q.push_back({b[3:0], 4'h0}); tag_q.push_back("R6 lower");
        bmode = 2;
        n_exp = ((m == 2) ? 2 : 3) * (16 * H + 1) + S;
        @(negedge clk);
        req_valid      = 1'b1;
        req_byte       = b;
        mode_set_valid = do_set;
        mode_set_data  = set_data;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid      = 1'b0;
        mode_set_valid = 1'b0;
        n = 0;
        while (!req_ready) begin
            n++;
            if (mid_set && n == 10) begin
                mode_set_valid = 1'b1;
                mode_set_data  = mid_data;
                bmode = mid_data ? 1 : 0;
            end else begin
                mode_set_valid = 1'b0;
            end
            @(negedge clk);
        end
        mode_set_valid = 1'b0;
        chk(n == n_exp, "R9 ready-low length", n, n_exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(ser_clk == 1'b0, "R1 ser_clk", ser_clk, 0);
        chk(ser_dat == 1'b0, "R1 ser_dat", ser_dat, 0);
        chk(ser_cs  == 1'b0, "R1 ser_cs", ser_cs, 0);
        chk(req_ready == 1'b1, "R1 ready", req_ready, 1);

        rst_level = 1'b1; #0.5;
        chk(disp_rst == 1'b1, "R2 reset high", disp_rst, 1);
        rst_level = 1'b0; #0.5;
        chk(disp_rst == 1'b0, "R2 reset low", disp_rst, 0);

        @(negedge clk);
        cs_en = 1'b1; #0.5;
        chk(ser_cs == 1'b0, "R3 cs not yet", ser_cs, 0);
        @(negedge clk);
        chk(ser_cs == 1'b1, "R3 cs asserted", ser_cs, 1);

        send(8'h3C, 0, 0, 0, 0, "R1 R4 command type");
        send(8'hA5, 0, 0, 0, 0, "R7 continue");
        set_mode(1'b1);
        send(8'h5A, 0, 0, 0, 0, "R5 data type");
        send(8'h0F, 0, 0, 0, 0, "R7 continue");
        send(8'hE1, 1, 0, 0, 0, "R10 same-cycle command");
        send(8'h96, 0, 0, 1, 1, "R11 in-flight frame");
        send(8'h7B, 0, 0, 0, 0, "R11 next data type");
        set_mode(1'b0);
        send(8'hFF, 1, 1, 0, 0, "R10 same-cycle data");
        send(8'h00, 0, 0, 0, 0, "R7 continue zero");

        @(negedge clk);
        cs_en = 1'b0;
        @(negedge clk);
        chk(ser_cs == 1'b0, "R3 cs released", ser_cs, 0);
        chk(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);
        chk(ser_clk == 1'b0 && ser_dat == 1'b0, "R1 link idle", {ser_clk, ser_dat}, 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule